// File: doc/BRIEF.md
# Snooping Instruction Cache

This block is a read-only first-level instruction cache. It sits between the fetch stage of a processor and a request bus to a unified second-level cache. A write-through data cache shares that bus. A fetch that hits returns its 32-bit word in the same cycle. A fetch that misses moves the cache into a fill state. In that state it asks the bus for the whole 128-bit block and stays there until the response addressed to it comes back.

The bus carries a source tag on every request and a destination tag on every response. Tag value 0 identifies this cache and tag value 1 identifies the data cache. The instruction cache claims the bus only when the bus is idle or already carries its own traffic. Every request it makes passes through one register stage on its way toward the second level.

The cache also watches the bus. Each write the data cache issues there invalidates any copy of the same block held here, so a later fetch of that block reloads it. A pipeline flush abandons a fill that is still pending.

Top module: `icache_snoop`

## Requirements
- R1: While reset is asserted and after it is released, every line is invalid, `fetch_ready_o` is 0 and `req_valid_o` is 0. The first fetch after reset misses.
- R2: Address fields are set = addr[6:4], tag = addr[31:7] and word = addr[3:2]. Word 0 occupies bits 31:0 of a block. A fetch in the lookup state that matches a valid line raises `fetch_ready_o` in the same cycle and returns the selected word.
- R3: A miss moves the cache to the fill state at the next edge. `fetch_ready_o` stays 0 for the whole fill. The read request appears on the `req_*` outputs one cycle after the cache issues it, with valid 1, write enable 0, source 0, write data 0 and the fetch address with its low 4 bits cleared.
- R4: The cache issues a request only in a cycle when `bus_valid_i` is 0 or `bus_src_i` is 0. In any other cycle it issues nothing and holds its state, and a response in such a cycle is not taken.
- R5: A fill is taken only when `rsp_ready_i` is 1 and `rsp_dst_i` is 0. Taking it writes the block and tag, marks the line valid, withdraws the request and returns to lookup, so the same fetch hits on the next cycle. A response with destination 1 is ignored.
- R6: A bus write from the data cache (`bus_valid_i`=1, `bus_wen_i`=1, `bus_src_i`=1) invalidates the line whose set and tag match `bus_addr_i`. Other lines are unchanged, and a bus read does not invalidate anything. A fetch of that same block in the same cycle is not reported as a hit.
- R7: `flush_i` during a fill returns the cache to lookup without writing any line, even if a valid response arrives in the same cycle. The request output drops on the next cycle.
- R8: The victim of a fill is the lowest-numbered invalid way of the set. When no way is invalid, the victim is the least recently used way. Hits and fills count as uses and snoops do not. After reset the use order of every set is way 0 newest through way 3 oldest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Fetch request, held with its address until served |
| fetch_addr_i | input | 32 | Fetch byte address |
| fetch_ready_o | output | 1 | Fetch served this cycle |
| fetch_data_o | output | 32 | Fetched instruction word |
| flush_i | input | 1 | Pipeline flush, abandons a pending fill |
| bus_valid_i | input | 1 | Shared request bus: valid |
| bus_wen_i | input | 1 | Shared request bus: write enable |
| bus_src_i | input | 1 | Shared request bus: source tag (0 instruction, 1 data) |
| bus_addr_i | input | 32 | Shared request bus: address |
| req_valid_o | output | 1 | Registered request toward L2: valid |
| req_wen_o | output | 1 | Registered request: write enable |
| req_src_o | output | 1 | Registered request: source tag |
| req_addr_o | output | 32 | Registered request: block address |
| req_wdata_o | output | 128 | Registered request: write data |
| rsp_ready_i | input | 1 | Response: data valid |
| rsp_dst_i | input | 1 | Response: destination tag |
| rsp_rdata_i | input | 128 | Response: block data |

## Verification
The bench holds a reference model of tags, validity and use order, and it mixes random fetches and snoops over six tags per set so that evictions happen often. Directed cases cover the following faults:

- A snoop that collides with a fetch of the same block. A cache without the hit mask would hand out the stale word.
- A busy bus carrying a response. A cache that ignored ownership would fill from a foreign transfer and never raise its request.
- A response tagged for the data cache. A cache that skipped the destination test would complete the fill with wrong data.
- A flush coinciding with a valid response. A cache that let the flush lose would keep the line, so the next fetch would hit instead of missing.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int unsigned BUS_AW = 32;
  localparam int unsigned BUS_DW = 128;
  localparam logic SRC_INSTR = 1'b0;
  localparam logic SRC_DATA  = 1'b1;

  typedef enum logic {ST_LOOKUP, ST_FILL} ic_state_e;

  typedef struct packed {
    logic              valid;
    logic              wen;
    logic              src;
    logic [BUS_AW-1:0] addr;
    logic [BUS_DW-1:0] wdata;
  } ic_req_t;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
  parameter int unsigned WAYS   = 4,
  parameter int unsigned SETS   = 8,
  parameter int unsigned TAG_W  = 25,
  parameter int unsigned DATA_W = 128,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned SET_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SET_W-1:0]  lk_set_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              lk_hit_o,
  output logic [WAY_W-1:0]  lk_way_o,
  output logic [DATA_W-1:0] lk_data_o,
  output logic [WAYS-1:0]   valid_vec_o,
  input  logic              fill_en_i,
  input  logic [WAY_W-1:0]  fill_way_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              inv_en_i,
  input  logic [SET_W-1:0]  inv_set_i,
  input  logic [TAG_W-1:0]  inv_tag_i
);
  logic [WAYS-1:0]   valid_q [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [DATA_W-1:0] data_q  [SETS][WAYS];
  logic [WAYS-1:0]   match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = valid_q[lk_set_i][g] && (tag_q[lk_set_i][g] == lk_tag_i);
  end

  always_comb begin
    lk_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) lk_way_o = WAY_W'(w);
    end
  end

  assign lk_hit_o    = |match;
  assign lk_data_o   = data_q[lk_set_i][lk_way_o];
  assign valid_vec_o = valid_q[lk_set_i];

  // snoop invalidation is written last so it wins over a same-line fill
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      if (fill_en_i) valid_q[lk_set_i][fill_way_i] <= 1'b1;
      if (inv_en_i) begin
        for (int w = 0; w < WAYS; w++) begin
          if (valid_q[inv_set_i][w] && tag_q[inv_set_i][w] == inv_tag_i)
            valid_q[inv_set_i][w] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      tag_q[lk_set_i][fill_way_i]  <= lk_tag_i;
      data_q[lk_set_i][fill_way_i] <= fill_data_i;
    end
  end
endmodule

// File: rtl/icache_lru.sv
module icache_lru #(
  parameter int unsigned WAYS = 4,
  parameter int unsigned SETS = 8,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned SET_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_en_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [SET_W-1:0] rd_set_i,
  input  logic [WAYS-1:0]  valid_vec_i,
  output logic [WAY_W-1:0] victim_o
);
  // per set: position 0 holds the newest way, position WAYS-1 the oldest
  logic [WAY_W-1:0] order_q [SETS][WAYS];
  logic [WAY_W-1:0] cur [WAYS];
  logic [WAY_W-1:0] nxt [WAYS];
  logic [WAY_W-1:0] pos;
  logic             found;

  always_comb begin
    pos = WAY_W'(WAYS - 1);
    for (int i = 0; i < WAYS; i++) begin
      cur[i] = order_q[touch_set_i][i];
      if (cur[i] == touch_way_i) pos = WAY_W'(i);
    end
    for (int i = 0; i < WAYS; i++) begin
      if (i == 0)               nxt[i] = touch_way_i;
      else if (i <= int'(pos))  nxt[i] = cur[i-1];
      else                      nxt[i] = cur[i];
    end
  end

  always_comb begin
    victim_o = order_q[rd_set_i][WAYS-1];
    found    = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (!valid_vec_i[i] && !found) begin
        victim_o = WAY_W'(i);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int i = 0; i < WAYS; i++) order_q[s][i] <= WAY_W'(i);
    end else if (touch_en_i) begin
      for (int i = 0; i < WAYS; i++) order_q[touch_set_i][i] <= nxt[i];
    end
  end
endmodule

// File: rtl/icache_req_stage.sv
module icache_req_stage
  import icache_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ic_req_t req_i,
  output ic_req_t req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_o <= '0;
    else         req_o <= req_i;
  end
endmodule

// File: rtl/icache_snoop.sv
module icache_snoop
  import icache_pkg::*;
#(
  parameter int unsigned WAYS = 4,
  parameter int unsigned SETS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [BUS_AW-1:0] fetch_addr_i,
  output logic              fetch_ready_o,
  output logic [31:0]       fetch_data_o,
  input  logic              flush_i,
  input  logic              bus_valid_i,
  input  logic              bus_wen_i,
  input  logic              bus_src_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  output logic              req_valid_o,
  output logic              req_wen_o,
  output logic              req_src_o,
  output logic [BUS_AW-1:0] req_addr_o,
  output logic [BUS_DW-1:0] req_wdata_o,
  input  logic              rsp_ready_i,
  input  logic              rsp_dst_i,
  input  logic [BUS_DW-1:0] rsp_rdata_i
);
  localparam int unsigned OFF_W  = $clog2(BUS_DW / 8);
  localparam int unsigned SET_W  = $clog2(SETS);
  localparam int unsigned TAG_W  = BUS_AW - SET_W - OFF_W;
  localparam int unsigned WAY_W  = $clog2(WAYS);
  localparam int unsigned WORDS  = BUS_DW / 32;
  localparam int unsigned WSEL_W = $clog2(WORDS);

  ic_state_e         state_q, state_d;
  ic_req_t           req_d, req_q;
  logic [SET_W-1:0]  f_set, s_set;
  logic [TAG_W-1:0]  f_tag, s_tag;
  logic              snoop_wr, snoop_same, bus_free, hit_ok, fill_en;
  logic              lk_hit;
  logic [WAY_W-1:0]  lk_way, victim;
  logic [BUS_DW-1:0] lk_data;
  logic [WAYS-1:0]   valid_vec;
  logic [31:0]       words [WORDS];
  logic [WSEL_W-1:0] wsel;

  assign f_set = fetch_addr_i[OFF_W +: SET_W];
  assign f_tag = fetch_addr_i[BUS_AW-1 -: TAG_W];
  assign s_set = bus_addr_i[OFF_W +: SET_W];
  assign s_tag = bus_addr_i[BUS_AW-1 -: TAG_W];
  assign wsel  = fetch_addr_i[OFF_W-1:2];

  assign snoop_wr   = bus_valid_i && bus_wen_i && (bus_src_i == SRC_DATA);
  assign snoop_same = snoop_wr && (s_set == f_set) && (s_tag == f_tag);
  assign bus_free   = !bus_valid_i || (bus_src_i == SRC_INSTR);
  // a line being invalidated this cycle must not be served
  assign hit_ok     = (state_q == ST_LOOKUP) && fetch_valid_i && lk_hit && !snoop_same;

  icache_tag_store #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .DATA_W(BUS_DW)
  ) tags_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_set_i    (f_set),
    .lk_tag_i    (f_tag),
    .lk_hit_o    (lk_hit),
    .lk_way_o    (lk_way),
    .lk_data_o   (lk_data),
    .valid_vec_o (valid_vec),
    .fill_en_i   (fill_en),
    .fill_way_i  (victim),
    .fill_data_i (rsp_rdata_i),
    .inv_en_i    (snoop_wr),
    .inv_set_i   (s_set),
    .inv_tag_i   (s_tag)
  );

  icache_lru #(.WAYS(WAYS), .SETS(SETS)) lru_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_en_i  (hit_ok || fill_en),
    .touch_set_i (f_set),
    .touch_way_i (fill_en ? victim : lk_way),
    .rd_set_i    (f_set),
    .valid_vec_i (valid_vec),
    .victim_o    (victim)
  );

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign words[g] = lk_data[g*32 +: 32];
  end

  assign fetch_ready_o = hit_ok;
  assign fetch_data_o  = words[wsel];

  always_comb begin
    state_d     = state_q;
    fill_en     = 1'b0;
    req_d.valid = 1'b0;
    req_d.wen   = 1'b0;
    req_d.src   = SRC_INSTR;
    req_d.addr  = {fetch_addr_i[BUS_AW-1:OFF_W], {OFF_W{1'b0}}};
    req_d.wdata = '0;
    unique case (state_q)
      ST_LOOKUP: begin
        if (fetch_valid_i && !hit_ok) state_d = ST_FILL;
      end
      ST_FILL: begin
        if (flush_i) begin
          state_d = ST_LOOKUP;
        end else if (bus_free) begin
          req_d.valid = 1'b1;
          if (rsp_ready_i && rsp_dst_i == SRC_INSTR) begin
            fill_en     = 1'b1;
            req_d.valid = 1'b0;
            state_d     = ST_LOOKUP;
          end
        end
      end
      default: state_d = ST_LOOKUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_LOOKUP;
    else         state_q <= state_d;
  end

  icache_req_stage req_stage_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_d),
    .req_o  (req_q)
  );

  assign req_valid_o = req_q.valid;
  assign req_wen_o   = req_q.wen;
  assign req_src_o   = req_q.src;
  assign req_addr_o  = req_q.addr;
  assign req_wdata_o = req_q.wdata;
endmodule

// File: rtl/icache_snoop_chk.sv
module icache_snoop_chk
  import icache_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_valid_i,
  input logic [BUS_AW-1:0] fetch_addr_i,
  input logic              fetch_ready_o,
  input logic              flush_i,
  input logic              bus_valid_i,
  input logic              bus_wen_i,
  input logic              bus_src_i,
  input logic [BUS_AW-1:0] bus_addr_i,
  input logic              req_valid_o,
  input logic              req_wen_o,
  input logic              req_src_o,
  input logic [BUS_AW-1:0] req_addr_o
);
  localparam int unsigned OFF_W = $clog2(BUS_DW / 8);

  AST_REQ_NEEDS_FREE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> $past(!bus_valid_i || bus_src_i == SRC_INSTR)); // R4

  AST_REQ_IS_BLOCK_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (!req_wen_o && req_src_o == SRC_INSTR && req_addr_o[OFF_W-1:0] == '0)); // R3

  AST_NO_READY_IN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !fetch_ready_o); // R3

  AST_READY_NEEDS_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_ready_o |-> fetch_valid_i); // R2

  AST_FLUSH_DROPS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !req_valid_o); // R7

  AST_SNOOP_MASKS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_wen_i && bus_src_i == SRC_DATA &&
     bus_addr_i[BUS_AW-1:OFF_W] == fetch_addr_i[BUS_AW-1:OFF_W]) |-> !fetch_ready_o); // R6
endmodule

bind icache_snoop icache_snoop_chk chk_i (.*);

// File: tb/icache_snoop_tb.sv
`timescale 1ns/1ps
module icache_snoop_tb_top;
  localparam int NS = 8;
  localparam int NW = 4;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic         fetch_valid, flush, bus_valid, bus_wen, bus_src, rsp_ready, rsp_dst;
  logic [31:0]  fetch_addr, bus_addr;
  logic [127:0] rsp_rdata;
  logic         fetch_ready, req_valid, req_wen, req_src;
  logic [31:0]  fetch_data, req_addr;
  logic [127:0] req_wdata;

  int n_tests = 0;
  int n_fail  = 0;

  bit           m_val [NS][NW];
  logic [24:0]  m_tag [NS][NW];
  logic [127:0] m_dat [NS][NW];
  int           m_ord [NS][NW];
  int           gen = 0;

  always #5 clk = ~clk;

  icache_snoop dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .fetch_valid_i(fetch_valid), .fetch_addr_i(fetch_addr),
    .fetch_ready_o(fetch_ready), .fetch_data_o(fetch_data),
    .flush_i(flush),
    .bus_valid_i(bus_valid), .bus_wen_i(bus_wen), .bus_src_i(bus_src), .bus_addr_i(bus_addr),
    .req_valid_o(req_valid), .req_wen_o(req_wen), .req_src_o(req_src),
    .req_addr_o(req_addr), .req_wdata_o(req_wdata),
    .rsp_ready_i(rsp_ready), .rsp_dst_i(rsp_dst), .rsp_rdata_i(rsp_rdata)
  );

  task automatic chk(string rq, logic [127:0] act, logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [127:0] blk(logic [31:0] a, int g);
    logic [127:0] r;
    for (int i = 0; i < 4; i++)
      r[i*32 +: 32] = {a[31:4], 2'(i), 2'b00} ^ (32'(g) * 32'h9E37_79B9);
    return r;
  endfunction

  function automatic int m_find(logic [31:0] a);
    int s = int'(a[6:4]);
    for (int w = 0; w < NW; w++)
      if (m_val[s][w] && m_tag[s][w] == a[31:7]) return w;
    return -1;
  endfunction

  function automatic void m_touch(int s, int w);
    int p = NW - 1;
    for (int i = 0; i < NW; i++) if (m_ord[s][i] == w) p = i;
    for (int i = p; i > 0; i--) m_ord[s][i] = m_ord[s][i-1];
    m_ord[s][0] = w;
  endfunction

  function automatic int m_victim(int s);
    for (int w = 0; w < NW; w++) if (!m_val[s][w]) return w;
    return m_ord[s][NW-1];
  endfunction

  function automatic void m_snoop(logic [31:0] a);
    int s = int'(a[6:4]);
    for (int w = 0; w < NW; w++)
      if (m_val[s][w] && m_tag[s][w] == a[31:7]) m_val[s][w] = 1'b0;
    gen++;
  endfunction

  task automatic quiet_bus();
    bus_valid = 0; bus_wen = 0; bus_src = 0; bus_addr = '0;
    rsp_ready = 0; rsp_dst = 0; rsp_rdata = '0; flush = 0;
  endtask

  // entered just after the edge that moved the cache into its fill state
  task automatic serve_miss(logic [31:0] a, bit own, bit wrong_dst, string rq);
    int n = 0;
    int s = int'(a[6:4]);
    int v;
    logic [127:0] d = blk(a, gen);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      quiet_bus();
      fetch_valid = 1; fetch_addr = a;
      if (own) begin bus_valid = 1; bus_src = 0; bus_addr = a; end
      #1;
      chk("R3 ready low in fill", fetch_ready, 0);
      if (req_valid) begin n = k; break; end
    end
    chk({rq, " request latency"}, n, 2);
    chk("R3 request fields", {req_wen, req_src, req_addr}, {1'b0, 1'b0, a[31:4], 4'h0});
    chk("R3 write data zero", req_wdata, '0);
    if (wrong_dst) begin
      rsp_ready = 1; rsp_dst = 1; rsp_rdata = ~d;
      @(negedge clk);
      rsp_ready = 0; rsp_dst = 0;
      #1;
      chk("R5 foreign response ignored, ready", fetch_ready, 0);
      chk("R5 foreign response ignored, request", req_valid, 1);
    end
    rsp_ready = 1; rsp_dst = 0; rsp_rdata = d;
    @(posedge clk);
    v = m_victim(s);
    m_val[s][v] = 1; m_tag[s][v] = a[31:7]; m_dat[s][v] = d;
    m_touch(s, v);
    @(negedge clk);
    quiet_bus();
    #1;
    chk({rq, " hit after fill"}, fetch_ready, 1);
    chk("R5 fill data", fetch_data, d[a[3:2]*32 +: 32]);
    chk("R5 request withdrawn", req_valid, 0);
    @(posedge clk);
    m_touch(s, v);
  endtask

  task automatic do_fetch(logic [31:0] a, string rq, bit own = 0, bit wrong_dst = 0);
    int w;
    int s = int'(a[6:4]);
    @(negedge clk);
    quiet_bus();
    fetch_valid = 1; fetch_addr = a;
    #1;
    w = m_find(a);
    chk({rq, " hit/miss"}, fetch_ready, (w >= 0));
    if (w >= 0) begin
      chk("R2 hit word", fetch_data, m_dat[s][w][a[3:2]*32 +: 32]);
      @(posedge clk);
      m_touch(s, w);
    end else begin
      @(posedge clk);
      serve_miss(a, own, wrong_dst, "R3");
    end
  endtask

  task automatic bus_op(logic [31:0] a, bit wen);
    @(negedge clk);
    quiet_bus();
    fetch_valid = 0;
    bus_valid = 1; bus_wen = wen; bus_src = 1; bus_addr = a;
    @(posedge clk);
    if (wen) m_snoop(a);
  endtask

  function automatic logic [31:0] mk(int tag, int set, int word);
    return (32'(tag) << 7) | (32'(set) << 4) | (32'(word) << 2);
  endfunction

  initial begin
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] b;
    void'($urandom(32'h5EED_1CAC));
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin m_val[s][w] = 0; m_ord[s][w] = w; end
    rst_ni = 0; fetch_valid = 0; fetch_addr = '0;
    quiet_bus();
    repeat (3) @(negedge clk);
    #1;
    chk("R1 ready in reset", fetch_ready, 0);
    chk("R1 request in reset", req_valid, 0);
    rst_ni = 1;
    @(negedge clk); #1;
    chk("R1 ready after reset", fetch_ready, 0);
    chk("R1 request after reset", req_valid, 0);

    do_fetch(mk(0, 2, 1), "R1");
    do_fetch(mk(0, 2, 2), "R2");
    do_fetch(mk(0, 2, 3), "R2");
    do_fetch(mk(0, 2, 0), "R2");

    // replacement order within set 2
    do_fetch(mk(1, 2, 0), "R8");
    do_fetch(mk(2, 2, 0), "R8");
    do_fetch(mk(3, 2, 0), "R8");
    do_fetch(mk(0, 2, 1), "R8");
    do_fetch(mk(4, 2, 0), "R8");
    do_fetch(mk(1, 2, 2), "R8");
    do_fetch(mk(0, 2, 3), "R8");
    do_fetch(mk(3, 2, 3), "R8");

    // snoop invalidation
    bus_op(mk(0, 2, 1), 1);
    do_fetch(mk(4, 2, 1), "R6");
    do_fetch(mk(0, 2, 2), "R6");
    bus_op(mk(9, 5, 0), 1);
    do_fetch(mk(4, 2, 2), "R6");
    bus_op(mk(4, 2, 0), 0);
    do_fetch(mk(4, 2, 3), "R6");

    // snoop colliding with a fetch of the same block
    b = mk(1, 3, 1);
    do_fetch(b, "R6");
    @(negedge clk);
    quiet_bus();
    fetch_valid = 1; fetch_addr = b;
    bus_valid = 1; bus_wen = 1; bus_src = 1; bus_addr = mk(1, 3, 2);
    #1;
    chk("R6 same-cycle snoop masks hit", fetch_ready, 0);
    @(posedge clk);
    m_snoop(mk(1, 3, 2));
    serve_miss(b, 0, 0, "R6");

    // bus held by the data cache during a fill
    b = mk(2, 4, 3);
    @(negedge clk);
    quiet_bus();
    fetch_valid = 1; fetch_addr = b;
    #1;
    chk("R3 miss", fetch_ready, 0);
    @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      quiet_bus();
      bus_valid = 1; bus_wen = 0; bus_src = 1; bus_addr = mk(7, 7, 0);
      rsp_ready = 1; rsp_dst = 0; rsp_rdata = {4{32'hDEAD_BEEF}};
      #1;
      chk("R4 no request while bus busy", req_valid, 0);
      chk("R3 ready low while bus busy", fetch_ready, 0);
      @(posedge clk);
    end
    serve_miss(b, 0, 0, "R4");

    do_fetch(mk(3, 4, 0), "R4", 1, 0);
    do_fetch(mk(5, 6, 2), "R5", 0, 1);

    // flush with a response in the same cycle
    b = mk(5, 1, 0);
    @(negedge clk);
    quiet_bus();
    fetch_valid = 1; fetch_addr = b;
    @(posedge clk);
    @(negedge clk);
    @(negedge clk); #1;
    chk("R7 request raised before flush", req_valid, 1);
    flush = 1; rsp_ready = 1; rsp_dst = 0; rsp_rdata = blk(b, gen);
    @(negedge clk);
    quiet_bus();
    fetch_valid = 0;
    #1;
    chk("R7 request dropped after flush", req_valid, 0);
    chk("R7 no ready after flush", fetch_ready, 0);
    do_fetch(b, "R7");

    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 10;
      logic [31:0] a = mk($urandom % 6, $urandom % 8, $urandom % 4);
      if (op < 7) do_fetch(a, "R8", bit'($urandom % 2), ($urandom % 5) == 0);
      else        bus_op(a, ($urandom % 4) != 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule